// File: doc/BRIEF.md
# Per-Cycle Ready-Thread Barrel Scheduler

This block chooses, on every clock cycle, one hardware thread to issue its next instruction into a shared pipeline. Each thread has a busy flag. The flag goes up when the thread is picked. It drops when the instruction reports that it has finished. A software no-dependence hint can also drop it early. Because a thread never issues again while its previous instruction is still in flight, the pipeline can hide its operation and memory latency without forwarding paths.

A per-thread block input keeps a thread out of the choice while it waits on a stall, a multiply, a divide or a load. Among the threads that are neither busy nor blocked, a rotating pointer chooses fairly. The search starts just past the last thread that issued. The chosen thread number and a valid flag leave the block from registers. The pool size is a parameter that may be set up to 128 threads. The default is 4.

Top module: `bsched_barrel`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `issue_valid` is 0 and `issue_tid` is 0. All busy flags are clear and the rotating pointer is at thread 0.
- R2: A thread that has issued is not chosen again until a completion or a hint names it.
- R3: A pulse on `cmpl_valid` with thread number `cmpl_tid` clears that thread's busy flag at the clock edge. The thread can then be chosen from the following cycle on.
- R4: A pulse on `hint_valid` with thread number `hint_tid` clears that thread's busy flag exactly as a completion does, even though its instruction has not finished.
- R5: A thread whose bit in `thr_block` is 1 is never chosen in that cycle, whatever its busy flag says.
- R6: The decision made at a clock edge appears on `issue_valid`/`issue_tid` right after that edge. The search runs in rising thread number with wrap-around, starting one above the thread last chosen. The first free thread found wins, so successive issues rotate among the free threads.
- R7: When every thread is busy or blocked, `issue_valid` is 0 for that cycle and `issue_tid` reads 0.
- R8: If the same thread is chosen and cleared by a completion or hint at the same edge, the clear is applied first and the issue wins. The thread stays busy and is not chosen in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_block | input | NUM_THREADS | Per-thread block (1 = waiting on stall, multiply, divide or load) |
| cmpl_valid | input | 1 | Completion pulse |
| cmpl_tid | input | TID_W | Thread whose instruction completed |
| hint_valid | input | 1 | No-dependence hint pulse |
| hint_tid | input | TID_W | Thread released early by the hint |
| issue_valid | output | 1 | A thread was chosen this cycle |
| issue_tid | output | TID_W | Chosen thread number (0 when not valid) |

## Verification
The hardest case to reach is R8. A completion for a thread must arrive at exactly the edge where that thread is the only free one and gets chosen. The stimulus first leaves every thread busy by letting idle cycles run until issue stops. It then sends a completion for one thread, which frees it. It sends a second completion for the same thread in the very next cycle, which lands on the edge that picks it. After that, an idle cycle must show no issue. A long mixed phase then drives block, completion and hint patterns from a shift-register sequence against a bench model of the requirements.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

  // Width of a thread number; at least one bit.
  function automatic int tid_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bsched_state_bank.sv
module bsched_state_bank #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] set_vec,
  input  logic          cmpl_valid,
  input  logic [TW-1:0] cmpl_tid,
  input  logic          hint_valid,
  input  logic [TW-1:0] hint_tid,
  output logic [NT-1:0] busy_q
);

  logic [NT-1:0] clr_vec;

  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign clr_vec[i] = (cmpl_valid && cmpl_tid == TW'(i)) ||
                        (hint_valid && hint_tid == TW'(i));

    always_ff @(posedge clk) begin
      if (rst)             busy_q[i] <= 1'b0;
      else if (set_vec[i]) busy_q[i] <= 1'b1;
      else if (clr_vec[i]) busy_q[i] <= 1'b0;
    end
  end

  // R3: completion frees the named thread unless it issues at that edge
  a_r3_cmpl_frees: assert property (@(posedge clk) disable iff (rst)
    (cmpl_valid && !set_vec[cmpl_tid]) |=> !busy_q[$past(cmpl_tid)]);

  // R4: hint frees the named thread the same way
  a_r4_hint_frees: assert property (@(posedge clk) disable iff (rst)
    (hint_valid && !set_vec[hint_tid]) |=> !busy_q[$past(hint_tid)]);

  // R8: an issue coinciding with a clear leaves the thread busy
  a_r8_issue_wins: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & clr_vec) != '0) |=> ((busy_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/bsched_rr_pick.sv
module bsched_rr_pick #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic [NT-1:0] elig,
  input  logic [TW-1:0] ptr,
  output logic          any,
  output logic [TW-1:0] idx
);

  // Walk offsets from far to near so the nearest eligible thread wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = NT - 1; k >= 0; k--) begin
      int c;
      c = int'(ptr) + k;
      if (c >= NT) c = c - NT;
      if (elig[c]) begin
        any = 1'b1;
        idx = TW'(c);
      end
    end
  end

endmodule

// File: rtl/bsched_barrel.sv
module bsched_barrel #(
  parameter  int NUM_THREADS = 4,
  localparam int TID_W       = bsched_pkg::tid_width(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] thr_block,
  input  logic                   cmpl_valid,
  input  logic [TID_W-1:0]       cmpl_tid,
  input  logic                   hint_valid,
  input  logic [TID_W-1:0]       hint_tid,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid
);

  localparam int          NT   = NUM_THREADS;
  localparam int          TW   = TID_W;
  localparam logic [TW-1:0] LAST = TW'(NT - 1);

  logic [NT-1:0] busy_q;
  logic [NT-1:0] elig;
  logic [NT-1:0] set_vec;
  logic [TW-1:0] ptr_q;
  logic          pick_any;
  logic [TW-1:0] pick_idx;

  assign elig = ~busy_q & ~thr_block;

  bsched_rr_pick #(.NT(NT), .TW(TW)) u_pick (
    .elig (elig),
    .ptr  (ptr_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  for (genvar i = 0; i < NT; i++) begin : g_set
    assign set_vec[i] = pick_any && (pick_idx == TW'(i));
  end

  bsched_state_bank #(.NT(NT), .TW(TW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_vec    (set_vec),
    .cmpl_valid (cmpl_valid),
    .cmpl_tid   (cmpl_tid),
    .hint_valid (hint_valid),
    .hint_tid   (hint_tid),
    .busy_q     (busy_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= '0;
      issue_valid <= 1'b0;
      issue_tid   <= '0;
    end else begin
      issue_valid <= pick_any;
      issue_tid   <= pick_any ? pick_idx : '0;
      if (pick_any) ptr_q <= (pick_idx == LAST) ? '0 : pick_idx + 1'b1;
    end
  end

  // R2: the thread just reported as issued is now marked busy
  a_r2_issued_busy: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> busy_q[issue_tid]);

  // R5: the issued thread was not blocked when it was chosen
  a_r5_not_blocked: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (($past(thr_block) & (NT'(1) << issue_tid)) == '0));

  // R7: no free thread means no issue
  a_r7_idle_when_none: assert property (@(posedge clk) disable iff (rst)
    (&($past(busy_q | thr_block))) |-> (!issue_valid && issue_tid == '0));

endmodule

// File: tb/bsched_barrel_bench.sv
`timescale 1ns/1ps
module bsched_barrel_bench;

  localparam int NT = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] thr_block = '0;
  logic          cmpl_valid = 1'b0;
  logic [TW-1:0] cmpl_tid = '0;
  logic          hint_valid = 1'b0;
  logic [TW-1:0] hint_tid = '0;
  logic          issue_valid;
  logic [TW-1:0] issue_tid;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [NT-1:0] m_busy;
  logic [TW-1:0] m_ptr;

  always #2.5 clk = ~clk;

  bsched_barrel #(.NUM_THREADS(NT)) u_bsched_barrel (
    .clk (clk), .rst (rst), .thr_block (thr_block),
    .cmpl_valid (cmpl_valid), .cmpl_tid (cmpl_tid),
    .hint_valid (hint_valid), .hint_tid (hint_tid),
    .issue_valid (issue_valid), .issue_tid (issue_tid)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, model the rising edge, compare after it.
  task automatic step(input string tag, input logic [NT-1:0] blk,
                      input logic cv, input logic [TW-1:0] ct,
                      input logic hv, input logic [TW-1:0] ht);
    logic [NT-1:0] el, clr, setv;
    logic          ev;
    logic [TW-1:0] et;
    thr_block = blk; cmpl_valid = cv; cmpl_tid = ct; hint_valid = hv; hint_tid = ht;
    el = ~m_busy & ~blk;
    ev = 1'b0; et = '0;
    for (int k = 0; k < NT; k++) begin
      int c = (int'(m_ptr) + k) % NT;
      if (!ev && el[c]) begin ev = 1'b1; et = TW'(c); end
    end
    clr = '0;
    if (cv) clr[ct] = 1'b1;
    if (hv) clr[ht] = 1'b1;
    setv = '0;
    if (ev) setv[et] = 1'b1;
    m_busy = (m_busy & ~clr) | setv;
    if (ev) m_ptr = TW'((int'(et) + 1) % NT);
    @(negedge clk);
    chk({tag, " valid"}, int'(issue_valid), int'(ev));
    chk({tag, " tid"}, int'(issue_tid), int'(et));
  endtask

  task automatic idle(input string tag);
    step(tag, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    m_busy = '0; m_ptr = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(issue_valid), 0);
    chk("R1 tid in reset", int'(issue_tid), 0);
    rst = 1'b0;
  endtask

  task automatic t_rotate();
    idle("R1 first pick");          // thread 0
    for (int i = 1; i < NT; i++) idle("R6 rotate");
    idle("R2 all busy");
    chk("R7 no issue", int'(issue_valid), 0);
  endtask

  task automatic t_complete();
    step("R3 cmpl edge", '0, 1'b1, 2'd2, 1'b0, '0);
    idle("R3 freed");
    chk("R3 freed thread", int'(issue_tid), 2);
    idle("R2 busy again");
  endtask

  task automatic t_hint();
    step("R4 hint edge", '0, 1'b0, '0, 1'b1, 2'd1);
    idle("R4 released");
    chk("R4 released thread", int'(issue_tid), 1);
  endtask

  task automatic t_block();
    for (int i = 0; i < NT; i++)
      step("R5 free all", 4'b0001, 1'b1, TW'(i), 1'b0, '0);
    for (int i = 0; i < 4; i++) begin
      step("R5 blocked", 4'b0001, 1'b0, '0, 1'b0, '0);
      chk("R5 not thread0", int'(issue_valid && issue_tid == 0), 0);
    end
    idle("R5 unblocked");
    chk("R5 thread0 issues", int'(issue_valid && issue_tid == 0), 1);
  endtask

  task automatic t_same();
    for (int i = 0; i < NT + 1; i++) idle("R8 drain");
    step("R8 free t3", '0, 1'b1, 2'd3, 1'b0, '0);
    step("R8 clash", '0, 1'b1, 2'd3, 1'b0, '0);
    chk("R8 t3 issued", int'(issue_tid), 3);
    idle("R8 after");
    chk("R8 stays busy", int'(issue_valid), 0);
  endtask

  task automatic t_mixed();
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R6 mixed", lf[3:0] & lf[7:4], lf[8], lf[10:9], lf[11] & lf[12], lf[14:13]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rotate();
    t_complete();
    t_hint();
    t_block();
    t_same();
    t_mixed();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule